// File: doc/BRIEF.md
# Command-List Blitter Engine

The engine moves and fills bytes in a shared 20-bit byte-addressed memory without help from a processor. A host loads a 24-bit program pointer and writes a command byte whose run bit is set. The engine then reads 12-byte records from the program stream. Each record describes a rectangle: the bytes of one row are handled by an inner loop, and rows by an outer loop. Every row can copy source bytes, write a constant pattern byte, or expand the bits of one source byte into pattern bytes. A pattern-equality compare can suppress individual writes, and it can also halt the whole run. After each record the engine reads one more byte from the stream as the next command. It keeps going while that byte has its run bit set, so records form a chain that needs no host action.

The memory port carries a request and takes back-pressure through a grant. While `mem_req` is high and `mem_gnt` is low, the engine holds `mem_addr`, `mem_we` and `mem_wdata` unchanged. A transfer completes in the cycle in which both are high. For a read, `mem_rdata` must be valid in that same cycle. The engine makes at most one access per cycle.

Top module: `blitter_engine`

## Requirements
- R1: Host writes with `reg_sel` 0, 1 and 2 load the program pointer bits [7:0], [15:8] and [23:16]. `reg_sel` 3 loads the command byte. A command byte with bit0 (run) set, written while idle, makes `busy` read 1 from the next cycle.
- R2: A record is 12 bytes read from consecutive pointer addresses, with the pointer advancing by one per byte read. The bytes are, in order: source address (3 bytes, least significant first, upper 4 bits of the third byte ignored), destination address (3 bytes, same layout), mode, function, outer count, inner count, step, pattern.
- R3: With command bit5 (source read) set and mode bit2 clear, each pixel reads the byte at the source address and writes it to the destination. Both addresses then advance by one, wrapping modulo 2^20.
- R4: With command bit5 clear and mode bit2 clear, each pixel writes the pattern byte.
- R5: Each row has inner-count pixels. After a row, the outer count drops by one and the record ends when it reaches zero. Otherwise the step byte is added to the destination address if command bit4 is set, and to the source address if bit3 is set, both modulo 2^20. A count of 0 means 256.
- R6: With command bit2 set, three bytes (new inner count, step, pattern) are read from the program stream between rows, after the step additions.
- R7: After a record ends, the next stream byte becomes the command. If its bit0 is set, a new record follows; otherwise the engine goes idle.
- R8: With mode bit2 set, the source byte is read only at the first pixel of a row, and only if command bit5 is set. The pattern is written unless source bit ((remaining count − 1) mod 8) is 0. Remaining counts run inner..1, so an inner count of 8 uses bits 7 down to 0. The source address advances by one after the last pixel of the row.
- R9: With function bit3 set, a pixel whose current source byte equals the pattern is not written. The destination address still advances by one after every pixel, written or not.
- R10: If such a compare match occurs while command bit1 is set, the engine stops at once without writing and goes idle.
- R11: A record whose destination address is 0 ends the run with no writes.
- R12: A request is held with unchanged address, direction and write data until it is granted.
- R13: `busy` is 0 after reset. When the engine returns to idle, `done` is 1 for exactly one cycle, with `busy` already 0. All host writes are ignored while busy.
- R14: With command bit6 set, every pixel reads the destination byte before its write decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Host register write strobe |
| reg_sel | input | 2 | Register select: 0..2 pointer bytes, 3 command |
| reg_wdata | input | 8 | Host write data |
| busy | output | 1 | Engine running |
| done | output | 1 | One-cycle pulse on return to idle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW (20) | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_gnt | input | 1 | Grant; transfer completes when high with request |
| mem_rdata | input | 8 | Read data, valid in the granted cycle |

## Verification
The end of a row and the compare-stop decision can land on the same pixel. When that pixel also carries a row step and a parameter reload, the stop must win: the step is not added, no reload bytes are read, and `done` follows directly. A directed record puts the matching source byte at the last pixel of the first row. The outcome is judged from the write log, which must end after the earlier pixels, and from `done`. Random grants stretch every access, and randomized programs mix compare, stop and reload so that these collisions also occur across record boundaries. Each run is compared with a bench model.

// File: rtl/blit_pkg.sv
package blit_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PIX_SRC,
    ST_PIX_DST,
    ST_PIX_WR,
    ST_RELOAD,
    ST_NEXT_CMD
  } blit_state_t;

  // command byte fields
  localparam int CB_RUN      = 0;
  localparam int CB_STOP     = 1;
  localparam int CB_RELOAD   = 2;
  localparam int CB_SRC_STEP = 3;
  localparam int CB_DST_STEP = 4;
  localparam int CB_SRC_EN   = 5;
  localparam int CB_DST_EN   = 6;

  // mode and function fields
  localparam int MB_EXPAND = 2;
  localparam int FB_CMP_EQ = 3;

  localparam int REC_BYTES    = 12;
  localparam int RELOAD_BYTES = 3;

endpackage

// File: rtl/blit_wrap_add.sv
module blit_wrap_add #(
  parameter int W  = 20,
  parameter int IW = 9
) (
  input  logic [W-1:0]  base,
  input  logic [IW-1:0] inc,
  output logic [W-1:0]  sum
);
  // modulo 2^W by truncation
  assign sum = base + W'(inc);
endmodule

// File: rtl/blit_pixel.sv
module blit_pixel (
  input  logic       expand,
  input  logic       src_en,
  input  logic       cmp_en,
  input  logic       stop_en,
  input  logic [7:0] src_data,
  input  logic [7:0] pattern,
  input  logic [2:0] bit_sel,
  output logic [7:0] wr_val,
  output logic       inhibit,
  output logic       collide
);
  logic bit_miss;
  logic match;

  assign bit_miss = expand && !src_data[bit_sel];
  assign match    = cmp_en && (src_data == pattern);
  assign inhibit  = bit_miss || match;
  assign collide  = match && stop_en;
  assign wr_val   = (!expand && src_en) ? src_data : pattern;
endmodule

// File: rtl/blitter_engine.sv
module blitter_engine #(
  parameter int AW = 20,
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [7:0]    reg_wdata,
  output logic          busy,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic          mem_gnt,
  input  logic [7:0]    mem_rdata
);
  import blit_pkg::*;

  localparam int IDXW     = $clog2(REC_BYTES);
  localparam int HDR_LAST = REC_BYTES - 1;
  localparam int RLD_LAST = RELOAD_BYTES - 1;
  localparam int INCW     = 9;

  blit_state_t   state;
  logic [PW-1:0] prog_ptr;
  logic [7:0]    cmd, mode, func, outer, inner, step, pattern, remaining, src_data;
  logic [AW-1:0] src_a, dst_a, src_sum, dst_sum;
  logic [IDXW-1:0] idx;
  logic          done_q;

  logic [23:0]     src_ins, dst_ins;
  logic [INCW-1:0] src_inc, dst_inc;
  logic            expand, need_src, row_end, xfer, proceed;
  logic [7:0]      px_val;
  logic            px_inhibit, px_collide;

  assign expand   = mode[MB_EXPAND];
  assign need_src = cmd[CB_SRC_EN] && (!expand || remaining == inner);
  assign row_end  = (remaining == 8'd1);

  blit_pixel u_pixel (
    .expand  (expand),
    .src_en  (cmd[CB_SRC_EN]),
    .cmp_en  (func[FB_CMP_EQ]),
    .stop_en (cmd[CB_STOP]),
    .src_data(src_data),
    .pattern (pattern),
    .bit_sel (3'(remaining - 8'd1)),
    .wr_val  (px_val),
    .inhibit (px_inhibit),
    .collide (px_collide)
  );

  // address increments
  always_comb begin
    src_inc = '0;
    dst_inc = '0;
    if (state == ST_PIX_SRC) begin
      src_inc = INCW'(1);
    end else if (state == ST_PIX_WR) begin
      dst_inc = INCW'(1);
      if (row_end) begin
        if (cmd[CB_DST_STEP]) dst_inc = dst_inc + INCW'(step);
        if (expand)           src_inc = INCW'(1);
        if (cmd[CB_SRC_STEP]) src_inc = src_inc + INCW'(step);
      end
    end
  end

  blit_wrap_add #(.W(AW), .IW(INCW)) u_src_add (.base(src_a), .inc(src_inc), .sum(src_sum));
  blit_wrap_add #(.W(AW), .IW(INCW)) u_dst_add (.base(dst_a), .inc(dst_inc), .sum(dst_sum));

  // header byte insertion into address registers
  always_comb begin
    src_ins = 24'(src_a);
    dst_ins = 24'(dst_a);
    case (idx)
      IDXW'(0): src_ins[7:0]   = mem_rdata;
      IDXW'(1): src_ins[15:8]  = mem_rdata;
      IDXW'(2): src_ins[23:16] = mem_rdata;
      IDXW'(3): dst_ins[7:0]   = mem_rdata;
      IDXW'(4): dst_ins[15:8]  = mem_rdata;
      IDXW'(5): dst_ins[23:16] = mem_rdata;
      default: ;
    endcase
  end

  // memory port
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = prog_ptr[AW-1:0];
    mem_wdata = px_val;
    case (state)
      ST_HDR, ST_RELOAD, ST_NEXT_CMD: mem_req = 1'b1;
      ST_PIX_SRC: begin
        mem_req  = need_src;
        mem_addr = src_a;
      end
      ST_PIX_DST: begin
        mem_req  = cmd[CB_DST_EN];
        mem_addr = dst_a;
      end
      ST_PIX_WR: begin
        mem_req  = !px_inhibit;
        mem_we   = 1'b1;
        mem_addr = dst_a;
      end
      default: ;
    endcase
  end

  assign xfer    = mem_req && mem_gnt;
  assign proceed = !mem_req || mem_gnt;
  assign busy    = (state != ST_IDLE);
  assign done    = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      prog_ptr  <= '0;
      cmd       <= '0;
      mode      <= '0;
      func      <= '0;
      outer     <= '0;
      inner     <= '0;
      step      <= '0;
      pattern   <= '0;
      remaining <= '0;
      src_data  <= '0;
      src_a     <= '0;
      dst_a     <= '0;
      idx       <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (reg_we) begin
            case (reg_sel)
              2'd0: prog_ptr[7:0]   <= reg_wdata;
              2'd1: prog_ptr[15:8]  <= reg_wdata;
              2'd2: prog_ptr[23:16] <= reg_wdata;
              default: begin
                cmd <= reg_wdata;
                if (reg_wdata[CB_RUN]) begin
                  idx   <= '0;
                  state <= ST_HDR;
                end
              end
            endcase
          end
        end
        ST_HDR: begin
          if (xfer) begin
            prog_ptr <= prog_ptr + 1'b1;
            idx      <= idx + 1'b1;
            case (idx)
              IDXW'(0), IDXW'(1), IDXW'(2): src_a <= src_ins[AW-1:0];
              IDXW'(3), IDXW'(4), IDXW'(5): dst_a <= dst_ins[AW-1:0];
              IDXW'(6):  mode  <= mem_rdata;
              IDXW'(7):  func  <= mem_rdata;
              IDXW'(8):  outer <= mem_rdata;
              IDXW'(9):  inner <= mem_rdata;
              IDXW'(10): step  <= mem_rdata;
              default: begin
                pattern   <= mem_rdata;
                remaining <= inner;
                src_data  <= '0;
                if (dst_a == '0) begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
                end else begin
                  state <= ST_PIX_SRC;
                end
              end
            endcase
          end
        end
        ST_PIX_SRC: begin
          if (!need_src) begin
            state <= ST_PIX_DST;
          end else if (xfer) begin
            src_data <= mem_rdata;
            if (!expand) src_a <= src_sum;
            state <= ST_PIX_DST;
          end
        end
        ST_PIX_DST: begin
          if (proceed) state <= ST_PIX_WR;
        end
        ST_PIX_WR: begin
          if (px_collide) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end else if (proceed) begin
            remaining <= remaining - 1'b1;
            dst_a     <= dst_sum;
            if (!row_end) begin
              state <= ST_PIX_SRC;
            end else if (outer == 8'd1) begin
              state <= ST_NEXT_CMD;
            end else begin
              outer <= outer - 1'b1;
              src_a <= src_sum;
              if (cmd[CB_RELOAD]) begin
                idx   <= '0;
                state <= ST_RELOAD;
              end else begin
                remaining <= inner;
                state     <= ST_PIX_SRC;
              end
            end
          end
        end
        ST_RELOAD: begin
          if (xfer) begin
            prog_ptr <= prog_ptr + 1'b1;
            idx      <= idx + 1'b1;
            case (idx)
              IDXW'(0): inner <= mem_rdata;
              IDXW'(1): step  <= mem_rdata;
              default: begin
                pattern   <= mem_rdata;
                remaining <= inner;
                state     <= ST_PIX_SRC;
              end
            endcase
          end
        end
        ST_NEXT_CMD: begin
          if (xfer) begin
            prog_ptr <= prog_ptr + 1'b1;
            cmd      <= mem_rdata;
            if (mem_rdata[CB_RUN]) begin
              idx   <= '0;
              state <= ST_HDR;
            end else begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R13
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !mem_we && (state == ST_HDR || state == ST_RELOAD || state == ST_NEXT_CMD))
      |=> (prog_ptr == $past(prog_ptr) + 1'b1));

  // R9
  dst_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PIX_WR && !px_collide && proceed && !row_end) |=> (dst_a == $past(dst_a) + 1'b1));

  // R10
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PIX_WR && px_collide) |-> (!mem_req ##1 (!busy && done)));

  initial begin
    if (AW > 24 || PW != 24) $error("blitter_engine: unsupported widths");
  end
endmodule

// File: tb/test_blitter_engine.sv
module test_blitter_engine;
  localparam int AW = 20;
  localparam int MSZ = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0;
  logic busy, done, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic mem_gnt = 1'b1;

  blitter_engine #(.AW(AW), .PW(24)) i_blitter_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
  );

  always #5 clk = ~clk;

  logic [7:0] mem  [MSZ];
  logic [7:0] smem [MSZ];
  assign mem_rdata = mem[mem_addr[12:0]];

  int checks = 0, fails = 0, cycles = 0;
  int log_n = 0, exp_n = 0, rd_cnt = 0, req_drop = 0;
  int win_lo = 0, win_hi = 0;
  logic [19:0] log_a [1024];
  logic [7:0]  log_d [1024];
  logic [19:0] exp_a [1024];
  logic [7:0]  exp_d [1024];
  bit gnt_rand = 1'b0;
  bit pend = 1'b0;
  logic [19:0] pend_a;
  logic pend_we;

  // memory model, grant generator, request monitor
  always @(negedge clk) begin
    logic g;
    if (rst_n) begin
      if (pend && !(mem_req && mem_addr == pend_a && mem_we == pend_we)) req_drop++;
      g = gnt_rand ? ($urandom_range(0, 3) != 0) : 1'b1;
      mem_gnt = g;
      pend = mem_req && !g;
      pend_a = mem_addr;
      pend_we = mem_we;
      if (mem_req && g && mem_we) begin
        mem[mem_addr[12:0]] = mem_wdata;
        if (log_n < 1024) begin
          log_a[log_n] = mem_addr;
          log_d[log_n] = mem_wdata;
        end
        log_n++;
      end
      if (mem_req && g && !mem_we && int'(mem_addr) >= win_lo && int'(mem_addr) < win_hi) rd_cnt++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog R13 actual=%0d expected=%0d", cycles, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [7:0] rd(input int a);
    return smem[a[12:0]];
  endfunction

  task automatic put(input int a, input logic [7:0] b);
    mem[a[12:0]] = b;
    smem[a[12:0]] = b;
  endtask

  task automatic put_b(inout int p, input logic [7:0] b);
    put(p, b);
    p++;
  endtask

  task automatic put_rec(inout int p, input logic [19:0] s, input logic [19:0] d,
                         input logic [7:0] mo, input logic [7:0] fu, input logic [7:0] ou,
                         input logic [7:0] inn, input logic [7:0] st, input logic [7:0] pa);
    put_b(p, s[7:0]); put_b(p, s[15:8]); put_b(p, {4'h0, s[19:16]});
    put_b(p, d[7:0]); put_b(p, d[15:8]); put_b(p, {4'h0, d[19:16]});
    put_b(p, mo); put_b(p, fu); put_b(p, ou); put_b(p, inn); put_b(p, st); put_b(p, pa);
  endtask

  // bench model of the requirements
  task automatic ref_run(input int ptr, input logic [7:0] c0);
    int pc, ie;
    logic [7:0] cmd, mode, func, outer, inner, step, pat, sd, b2;
    logic [19:0] s, d;
    bit inh, ex;
    exp_n = 0;
    pc = ptr;
    cmd = c0;
    while (cmd[0]) begin
      b2 = rd(pc + 2); s = {b2[3:0], rd(pc + 1), rd(pc)};
      b2 = rd(pc + 5); d = {b2[3:0], rd(pc + 4), rd(pc + 3)};
      mode = rd(pc + 6); func = rd(pc + 7); outer = rd(pc + 8);
      inner = rd(pc + 9); step = rd(pc + 10); pat = rd(pc + 11);
      pc += 12;
      if (d == 0) return;                                  // R11
      sd = 0;
      ex = mode[2];
      forever begin
        ie = (inner == 0) ? 256 : int'(inner);
        for (int k = ie; k >= 1; k--) begin
          if (cmd[5] && (!ex || 8'(k) == inner)) begin
            sd = rd(int'(s));
            if (!ex) s = s + 1'b1;                         // R3
          end
          inh = ex ? !sd[3'(k - 1)] : 1'b0;                // R8
          if (func[3] && sd == pat) begin                  // R9
            inh = 1'b1;
            if (cmd[1]) return;                            // R10
          end
          if (!inh) begin
            exp_a[exp_n] = d;
            exp_d[exp_n] = (!ex && cmd[5]) ? sd : pat;     // R4
            smem[d[12:0]] = exp_d[exp_n];
            exp_n++;
          end
          d = d + 1'b1;
          if (ex && k == 1) s = s + 1'b1;
        end
        outer = outer - 1'b1;                              // R5
        if (outer == 0) break;
        if (cmd[4]) d = d + 20'(step);
        if (cmd[3]) s = s + 20'(step);
        if (cmd[2]) begin                                  // R6
          inner = rd(pc); step = rd(pc + 1); pat = rd(pc + 2);
          pc += 3;
        end
      end
      cmd = rd(pc);                                        // R7
      pc++;
    end
  endtask

  task automatic host_write(input logic [1:0] sel, input logic [7:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic start(input int ptr, input logic [7:0] c);
    host_write(2'd0, ptr[7:0]);
    host_write(2'd1, ptr[15:8]);
    host_write(2'd2, ptr[23:16]);
    log_n = 0;
    rd_cnt = 0;
    host_write(2'd3, c);
  endtask

  task automatic wait_done(input string tag);
    int t = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    check(done === 1'b1, {tag, " R13 done pulse"}, int'(done), 1);
    check(busy === 1'b0, {tag, " R13 busy low at done"}, int'(busy), 0);
  endtask

  task automatic compare_log(input string tag);
    int bad = 0;
    check(log_n == exp_n, {tag, " write count"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n && i < 1024; i++)
      if (log_a[i] !== exp_a[i] || log_d[i] !== exp_d[i]) begin
        if (bad == 0) check(1'b0, {tag, " write content"}, int'({log_a[i], log_d[i]}), int'({exp_a[i], exp_d[i]}));
        bad++;
      end
    if (bad == 0) check(1'b1, {tag, " write content"}, 0, 0);
  endtask

  task automatic run(input string tag, input int ptr, input logic [7:0] c);
    ref_run(ptr, c);
    start(ptr, c);
    wait_done(tag);
    compare_log(tag);
  endtask

  function automatic logic [7:0] pick();
    case ($urandom_range(0, 3))
      0: return 8'h55;
      1: return 8'hAA;
      2: return 8'h0F;
      default: return 8'hF0;
    endcase
  endfunction

  initial begin
    int p;
    logic [7:0] cseq [4];
    void'($urandom(32'd1234567));
    for (int i = 0; i < MSZ; i++) put(i, 8'h00);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    check(busy === 1'b0, "R13 reset busy", int'(busy), 0);
    check(done === 1'b0, "R13 reset done", int'(done), 0);
    check(mem_req === 1'b0, "R12 reset request", int'(mem_req), 0);

    // R1 R3 plain copy
    for (int i = 0; i < 6; i++) put(32'h400 + i, 8'(8'h10 + i));
    p = 32'h100;
    put_rec(p, 20'h00400, 20'h01000, 8'h00, 8'h00, 8'd1, 8'd6, 8'd0, 8'h00);
    put_b(p, 8'h00);
    ref_run(32'h100, 8'h21);
    start(32'h100, 8'h21);
    check(busy === 1'b1, "R1 busy after start", int'(busy), 1);
    wait_done("R1 R3 copy");
    compare_log("R3 copy");

    // R4 R5 fill with destination row step
    p = 32'h100;
    put_rec(p, 20'h00400, 20'h01100, 8'h00, 8'h00, 8'd3, 8'd4, 8'd5, 8'h77);
    put_b(p, 8'h00);
    run("R4 R5 fill step", 32'h100, 8'h11);

    // R5 address wrap with source and destination step
    p = 32'h100;
    put_rec(p, 20'hFFFFE, 20'hFFFFE, 8'h00, 8'h00, 8'd2, 8'd4, 8'd3, 8'h00);
    put_b(p, 8'h00);
    run("R5 wrap", 32'h100, 8'h39);

    // R6 parameter reload between rows
    p = 32'h100;
    put_rec(p, 20'h00400, 20'h01200, 8'h00, 8'h00, 8'd3, 8'd2, 8'd4, 8'h31);
    put_b(p, 8'd3); put_b(p, 8'd2); put_b(p, 8'h32);
    put_b(p, 8'd5); put_b(p, 8'd1); put_b(p, 8'h33);
    put_b(p, 8'h00);
    run("R6 reload", 32'h100, 8'h15);

    // R7 R2 chained records
    p = 32'h100;
    put_rec(p, 20'h00400, 20'h01300, 8'h00, 8'h00, 8'd1, 8'd3, 8'd0, 8'h00);
    put_b(p, 8'h01);
    put_rec(p, 20'h00400, 20'h01340, 8'h00, 8'h00, 8'd2, 8'd2, 8'd0, 8'h9C);
    put_b(p, 8'h20);
    run("R7 R2 chain", 32'h100, 8'h21);

    // R8 bit-to-byte expansion
    put(32'h420, 8'hA5); put(32'h421, 8'h3C);
    p = 32'h100;
    put_rec(p, 20'h00420, 20'h01400, 8'h04, 8'h00, 8'd2, 8'd8, 8'd0, 8'hEE);
    put_b(p, 8'h00);
    run("R8 expand", 32'h100, 8'h21);

    // R9 compare inhibit, destination still advances
    put(32'h430, 8'h11); put(32'h431, 8'h55); put(32'h432, 8'h22); put(32'h433, 8'h55);
    p = 32'h100;
    put_rec(p, 20'h00430, 20'h01500, 8'h00, 8'h08, 8'd1, 8'd4, 8'd0, 8'h55);
    put_b(p, 8'h00);
    run("R9 compare", 32'h100, 8'h21);

    // R10 stop on the last pixel of a row that would step and reload
    gnt_rand = 1'b1;
    put(32'h440, 8'h11); put(32'h441, 8'h22); put(32'h442, 8'h55);
    p = 32'h100;
    put_rec(p, 20'h00440, 20'h01600, 8'h00, 8'h08, 8'd3, 8'd3, 8'd4, 8'h55);
    put_b(p, 8'd2); put_b(p, 8'd1); put_b(p, 8'h00);
    put_b(p, 8'd2); put_b(p, 8'd1); put_b(p, 8'h00);
    put_b(p, 8'h00);
    run("R10 stop at row end", 32'h100, 8'h3F);

    // R11 zero destination
    p = 32'h100;
    put_rec(p, 20'h00400, 20'h00000, 8'h00, 8'h00, 8'd2, 8'd2, 8'd0, 8'h44);
    put_b(p, 8'h21);
    run("R11 zero dest", 32'h100, 8'h01);

    // R14 destination reads
    win_lo = 32'h1700; win_hi = 32'h1710;
    p = 32'h100;
    put_rec(p, 20'h00400, 20'h01700, 8'h00, 8'h00, 8'd1, 8'd3, 8'd0, 8'h66);
    put_b(p, 8'h00);
    run("R14 dst read", 32'h100, 8'h41);
    check(rd_cnt == 3, "R14 dst read count", rd_cnt, 3);
    win_lo = 0; win_hi = 0;

    // R13 host writes ignored while busy
    p = 32'h100;
    put_rec(p, 20'h00400, 20'h01800, 8'h00, 8'h00, 8'd12, 8'd12, 8'd2, 8'h5A);
    put_b(p, 8'h00);
    ref_run(32'h100, 8'h11);
    start(32'h100, 8'h11);
    repeat (40) @(negedge clk);
    host_write(2'd0, 8'h00);
    host_write(2'd3, 8'h23);
    wait_done("R13 busy ignore");
    compare_log("R13 busy ignore");

    // randomized programs
    for (int t = 0; t < 30; t++) begin
      int nrec;
      logic [7:0] ou;
      for (int i = 32'h400; i < 32'h800; i++) put(i, pick());
      nrec = $urandom_range(1, 3);
      for (int r = 0; r < nrec; r++) cseq[r] = 8'h01 | (8'($urandom) & 8'h7E);
      cseq[nrec] = 8'($urandom) & 8'h7E;
      p = 32'h100;
      for (int r = 0; r < nrec; r++) begin
        ou = 8'($urandom_range(1, 4));
        put_rec(p, 20'(32'h400 + $urandom_range(0, 32'h2FF)), 20'(32'h1000 + $urandom_range(0, 32'h7FF)),
                ($urandom_range(0, 1) != 0) ? 8'h04 : 8'h00,
                ($urandom_range(0, 3) == 0) ? 8'h08 : 8'h00,
                ou, 8'($urandom_range(1, 10)), 8'($urandom_range(0, 15)), pick());
        if (cseq[r][2])
          for (int k = 1; k < int'(ou); k++) begin
            put_b(p, 8'($urandom_range(1, 10)));
            put_b(p, 8'($urandom_range(0, 15)));
            put_b(p, pick());
          end
        put_b(p, cseq[r + 1]);
      end
      run($sformatf("R2 R3 R8 R9 random %0d", t), 32'h100, cseq[0]);
    end

    check(req_drop == 0, "R12 request held until grant", req_drop, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule